// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block is a finite impulse response filter that needs no multiplier. Its coefficient set is fixed when the design is elaborated. Each accepted sample enters a tap delay line. The filter then forms the inner product of the delay line with the coefficients, one bit position per clock.

For each bit position, the bit at that position is taken from every stored sample. Together these bits address a constant table. Each table entry holds the sum of the coefficients whose address bit is set. The table output is shifted left by the bit position and added into a wide accumulator. At the sign position it is subtracted instead, because samples are two's complement.

The taps can be split into equal groups. Each group then has its own smaller table, and the group outputs are summed every cycle. A result takes as many clocks as a sample has bits, however many taps there are. While a pass is running, `ready_o` is low.

Top module: `da_fir`

## Requirements
- R1: After reset, `ready_o` is 1, `done_o` is 0 and `y_o` is 0. Every tap of the delay line holds zero, so the first result equals coefficient 0 times the first sample.
- R2: A sample is accepted on a clock edge where `in_valid_i` and `ready_o` are both 1. It enters tap 0, every older sample moves one tap further, and the oldest sample is dropped.
- R3: `ready_o` is 0 from the edge that accepts a sample until the cycle in which `done_o` is 1. A sample offered while `ready_o` is 0 changes neither the current result nor the delay line.
- R4: `done_o` is high for exactly one cycle. That cycle starts WIDTH clock edges after the accepting edge, for every tap count and partition count.
- R5: At `done_o`, `y_o` equals the sum over k of c_k times x_k. Here x_k is the two's complement sample in tap k, with tap 0 the newest. c_k is the signed CW-bit field COEFS[k*CW +: CW].
- R6: `y_o` holds its value in every cycle where `done_o` is 0.
- R7: With coefficients (2, 3, 1) for taps 0..2, feeding samples 1, 3 and 7 gives 2, 9 and 24.
- R8: A filter whose table is split into NPART equal tap groups gives the same result as the direct sum of products. NPART must divide NTAPS.
- R9: No overflow occurs when every tap holds the most negative sample value, -2^(WIDTH-1). `y_o` is OW = WIDTH+CW+clog2(NTAPS)+1 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A sample is offered |
| sample_i | input | WIDTH | Two's complement input sample |
| ready_o | output | 1 | Filter is idle and can accept a sample |
| done_o | output | 1 | One-cycle strobe: `y_o` holds a new result |
| y_o | output | OW | Signed filter output |

## Verification
The short positive sequence 1, 3, 7 confirms the basic table sums and the tap ordering. A run of the most negative sample separates a correct subtraction at the sign position from plain addition, and it exercises the full accumulator width. A mixed-sign sequence with zeros runs through one 3-tap filter and two 6-tap filters split into two and three groups, which shows whether the group outputs are summed correctly. A sample held on the input during a pass, and a reset in mid-history, show that the delay line moves only on acceptance and is cleared by reset.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;
endpackage

// File: rtl/da_fir_taps.sv
module da_fir_taps #(
  parameter int NTAPS = 3,
  parameter int WIDTH = 4,
  localparam int BW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] sample_i,
  input  logic [BW-1:0]    bit_sel_i,
  output logic [NTAPS-1:0] slice_o
);
  logic [WIDTH-1:0] line_q [NTAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NTAPS; k++) line_q[k] <= '0;
    end else if (shift_i) begin
      line_q[0] <= sample_i;
      for (int k = 1; k < NTAPS; k++) line_q[k] <= line_q[k-1];
    end
  end

  // same bit position from every tap forms the table address
  always_comb begin
    for (int k = 0; k < NTAPS; k++) slice_o[k] = line_q[k][bit_sel_i];
  end
endmodule

// File: rtl/da_fir_lut.sv
module da_fir_lut #(
  parameter int GTAPS = 3,
  parameter int CW    = 4,
  parameter logic [GTAPS*CW-1:0] COEFS = '0,
  localparam int PSW = CW + $clog2(GTAPS) + 1
) (
  input  logic [GTAPS-1:0]      addr_i,
  output logic signed [PSW-1:0] psum_o
);
  localparam int NENT = 1 << GTAPS;

  function automatic logic signed [PSW-1:0] entry(input int a);
    logic signed [PSW-1:0] s;
    s = '0;
    for (int j = 0; j < GTAPS; j++)
      if (a[j]) s = s + PSW'($signed(COEFS[j*CW +: CW]));
    return s;
  endfunction

  logic signed [PSW-1:0] table_w [NENT];

  for (genvar a = 0; a < NENT; a++) begin : g_ent
    assign table_w[a] = entry(a);
  end

  assign psum_o = table_w[addr_i];
endmodule

// File: rtl/da_fir_acc.sv
module da_fir_acc
  import da_fir_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int OW    = 11,
  parameter int PSW   = 6,
  localparam int BW = $clog2(WIDTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [PSW-1:0] psum_i,
  output logic [BW-1:0]        bit_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic signed [OW-1:0] y_o
);
  run_state_e            state_q;
  logic [BW-1:0]         bit_q;
  logic signed [OW-1:0]  acc_q, y_q, term, acc_next;
  logic                  done_q, last;

  always_comb begin
    term     = OW'(psum_i) <<< bit_q;
    last     = (bit_q == BW'(WIDTH - 1));
    // sign position carries negative weight
    acc_next = last ? acc_q - term : acc_q + term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      acc_q   <= '0;
      y_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          bit_q   <= '0;
          acc_q   <= '0;
        end
        default: begin
          acc_q <= acc_next;
          if (last) begin
            y_q     <= acc_next;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign bit_o  = bit_q;
  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
  assign y_o    = y_q;
endmodule

// File: rtl/da_fir.sv
module da_fir #(
  parameter int NTAPS = 3,
  parameter int WIDTH = 4,
  parameter int CW    = 4,
  parameter int NPART = 1,
  parameter logic [NTAPS*CW-1:0] COEFS = 12'h132,
  localparam int OW  = WIDTH + CW + $clog2(NTAPS) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [WIDTH-1:0]     sample_i,
  output logic                 ready_o,
  output logic                 done_o,
  output logic signed [OW-1:0] y_o
);
  localparam int GT  = NTAPS / NPART;
  localparam int PSW = CW + $clog2(GT) + 1;
  localparam int PST = PSW + $clog2(NPART) + 1;
  localparam int BW  = $clog2(WIDTH);

  logic                  busy_w, start_w;
  logic [BW-1:0]         bit_w;
  logic [NTAPS-1:0]      slice_w;
  logic signed [PSW-1:0] part_w [NPART];
  logic signed [PST-1:0] psum_w;

  assign ready_o = !busy_w;
  assign start_w = in_valid_i && ready_o;

  da_fir_taps #(.NTAPS(NTAPS), .WIDTH(WIDTH)) u_taps (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (start_w),
    .sample_i  (sample_i),
    .bit_sel_i (bit_w),
    .slice_o   (slice_w)
  );

  for (genvar p = 0; p < NPART; p++) begin : g_part
    da_fir_lut #(
      .GTAPS (GT),
      .CW    (CW),
      .COEFS (COEFS[p*GT*CW +: GT*CW])
    ) u_lut (
      .addr_i (slice_w[p*GT +: GT]),
      .psum_o (part_w[p])
    );
  end

  always_comb begin
    psum_w = '0;
    for (int p = 0; p < NPART; p++) psum_w = psum_w + PST'(part_w[p]);
  end

  da_fir_acc #(.WIDTH(WIDTH), .OW(OW), .PSW(PST)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .psum_i  (psum_w),
    .bit_o   (bit_w),
    .busy_o  (busy_w),
    .done_o  (done_o),
    .y_o     (y_o)
  );
endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
  parameter int WIDTH = 4,
  parameter int OW    = 11
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic                 ready_o,
  input logic                 done_o,
  input logic signed [OW-1:0] y_o
);
  localparam int CNTW = $clog2(WIDTH + 2);
  logic [CNTW-1:0] cnt_q;
  logic            run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (in_valid_i && ready_o) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q && cnt_q != CNTW'(WIDTH + 1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_accept_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ready_o) |=> !ready_o);
  assert_done_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_q && cnt_q == CNTW'(WIDTH)));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(y_o));
endmodule

bind da_fir da_fir_chk #(.WIDTH(WIDTH), .OW(OW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .ready_o    (ready_o),
  .done_o     (done_o),
  .y_o        (y_o)
);

// File: tb/da_fir_test.sv
module da_fir_test;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 4;
  localparam int OW3 = W + 4 + 2 + 1;
  localparam int OW6 = W + 4 + 3 + 1;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] sample = '0;
  logic rdy3, dn3, rdy6a, dn6a, rdy6b, dn6b;
  logic signed [OW3-1:0] y3;
  logic signed [OW6-1:0] y6a, y6b;

  int c3[3] = '{2, 3, 1};
  int c6[6] = '{6, 1, 3, -8, 7, -5};
  int h3[3], h6[6];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  da_fir #(.NTAPS(3), .WIDTH(W), .CW(4), .NPART(1), .COEFS(12'h132)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .sample_i(sample),
    .ready_o(rdy3), .done_o(dn3), .y_o(y3));
  da_fir #(.NTAPS(6), .WIDTH(W), .CW(4), .NPART(2), .COEFS(24'hB78316)) uut_p2 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .sample_i(sample),
    .ready_o(rdy6a), .done_o(dn6a), .y_o(y6a));
  da_fir #(.NTAPS(6), .WIDTH(W), .CW(4), .NPART(3), .COEFS(24'hB78316)) uut_p3 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .sample_i(sample),
    .ready_o(rdy6b), .done_o(dn6b), .y_o(y6b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model3();
    int s = 0;
    for (int k = 0; k < 3; k++) s += c3[k] * h3[k];
    return s;
  endfunction

  function automatic int model6();
    int s = 0;
    for (int k = 0; k < 6; k++) s += c6[k] * h6[k];
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    for (int k = 0; k < 3; k++) h3[k] = 0;
    for (int k = 0; k < 6; k++) h6[k] = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // sample s; optionally hold in_valid with value pv while busy
  task automatic push(input int s, input bit poke, input int pv, input string tag);
    int y3p, y6p;
    @(negedge clk);
    check(rdy3 && rdy6a && rdy6b, "R2 ready before accept", int'(rdy3), 1);
    in_valid = 1'b1;
    sample = W'(s);
    @(posedge clk);
    for (int k = 2; k > 0; k--) h3[k] = h3[k-1];
    h3[0] = s;
    for (int k = 5; k > 0; k--) h6[k] = h6[k-1];
    h6[0] = s;
    @(negedge clk);
    in_valid = poke;
    sample = W'(pv);
    repeat (W - 1) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(!dn3 && !dn6a && !dn6b, "R4 done early", int'(dn3), 0);
    check(!rdy3 && !rdy6a && !rdy6b, "R3 ready while busy", int'(rdy3), 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(dn3 && dn6a && dn6b, "R4 done at WIDTH clocks", int'(dn3), 1);
    check(rdy3, "R3 ready at done", int'(rdy3), 1);
    check(int'(y3) == model3(), {tag, " R5 3-tap"}, int'(y3), model3());
    check(int'(y6a) == model6(), {tag, " R8 two groups"}, int'(y6a), model6());
    check(int'(y6b) == model6(), {tag, " R8 three groups"}, int'(y6b), model6());
    y3p = int'(y3);
    y6p = int'(y6a);
    @(posedge clk);
    @(negedge clk);
    check(!dn3 && !dn6a, "R4 single-cycle done", int'(dn3), 0);
    check(int'(y3) == y3p && int'(y6a) == y6p, "R6 hold", int'(y3), y3p);
  endtask

  task automatic t_reset();
    do_reset();
    check(rdy3 && rdy6a && rdy6b, "R1 ready", int'(rdy3), 1);
    check(!dn3 && !dn6a && !dn6b, "R1 done", int'(dn3), 0);
    check(y3 == 0 && y6a == 0 && y6b == 0, "R1 y", int'(y3), 0);
  endtask

  task automatic t_reference();
    do_reset();
    push(1, 0, 0, "R7");
    check(int'(y3) == 2, "R7 first", int'(y3), 2);
    push(3, 0, 0, "R7");
    check(int'(y3) == 9, "R7 second", int'(y3), 9);
    push(7, 0, 0, "R7");
    check(int'(y3) == 24, "R7 third", int'(y3), 24);
  endtask

  task automatic t_extreme();
    for (int i = 0; i < 6; i++) push(-8, 0, 0, "R9");
    check(int'(y3) == -48, "R9 3-tap min", int'(y3), -48);
    check(int'(y6a) == -32, "R9 6-tap min", int'(y6a), -32);
  endtask

  task automatic t_mixed();
    int pat[6] = '{5, -3, 0, 7, -1, 2};
    foreach (pat[i]) push(pat[i], 0, 0, "R2");
  endtask

  task automatic t_ignore();
    push(4, 1, -7, "R3");
    push(-2, 0, 0, "R3");
    check(h3[1] == 4, "R3 poke not in history", h3[1], 4);
  endtask

  task automatic t_clear();
    push(6, 0, 0, "R2");
    do_reset();
    push(3, 0, 0, "R1");
    check(int'(y3) == 6, "R1 delay line cleared", int'(y3), 6);
    check(int'(y6b) == 18, "R1 delay line cleared 6-tap", int'(y6b), 18);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_reference();
    t_extreme();
    t_mixed();
    t_ignore();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule